// File: doc/BRIEF.md
# DDR3 Power-Up Initialization Sequencer

This block takes one DDR3 channel from power-up to a state where normal traffic may begin. When it sees a start pulse it holds the on-die termination of every rank low, pulls the DRAM reset low with clock-enable held off, releases the reset, and then waits for the device to stabilise. It then turns on the DRAM clock and raises clock-enable only on the populated ranks. Once the exit time has passed, it writes the four mode registers and issues a long ZQ calibration through a valid/ready command port. Every wait is a parameter counted in controller clock cycles.

The mode-register words are built inside the block from the configured CAS latency, CAS write latency, write recovery, the dual-DIMM flag and a write-termination select. Write-recovery values that cannot be encoded are rejected before anything touches the pins. On a resume from suspend the DRAM contents must survive, so the block reports completion at once and leaves every pin alone. If the command port does not accept a command within a programmable number of cycles, the block stops in an error state and freezes its pins.

Top module: `ddr3_powerup_seq`

## Requirements
- R1: After reset the block is idle: dram_reset_n is 1; cke, dram_clk_en, odt_force_low, cmd_valid, done and error are all 0.
- R2: A start pulse with resume high makes done 1 on the next clock edge, and done stays 1. dram_reset_n never goes low, no command is presented, and dram_clk_en and cke stay 0.
- R3: odt_force_low rises at least one cycle before dram_reset_n falls. It stays 1 until the ZQ command has been accepted and falls together with the rise of done.
- R4: While dram_reset_n is 0, cke is 0 on all ranks.
- R5: dram_reset_n stays low for at least T_RESET_CYC cycles. After it rises, dram_clk_en stays 0 for at least T_STAB_CYC cycles.
- R6: After dram_clk_en rises, cke stays 0 for at least T_CKSRX_CYC cycles. cke then becomes equal to rank_map, and cmd_valid stays low for at least T_XPR_CYC further cycles.
- R7: Exactly five commands are accepted, in a fixed order. The first four are mode-register writes (cmd_is_zq=0) with cmd_bank 2, 3, 1 and 0 in that order. The fifth is a ZQ calibration (cmd_is_zq=1, cmd_bank 0, cmd_addr 16'h0400). cmd_ranks equals rank_map for all five, and done rises after the fifth.
- R8: The bank-0 word holds code = CL-4: code bit 3 at address bit 2 and code bits 2:0 at address bits 6:4. Address bit 8 is 1, the write-recovery field is at bits 11:9, and all other bits are 0.
- R9: For tWR from 5 to 16, the write-recovery field is 1,2,3,4,5,5,6,6,7,7,0,0. A tWR outside 5..16 sets error on the edge after start, with no reset pulse and no command.
- R10: The bank-1 word has bit 1 set. Bit 2 is set when dual_dimm is 1, and all other bits are 0.
- R11: The bank-2 word holds CWL-5 at bits 5:3, and bits 10:9 hold 2'b10 when rtt_wr_hi is 1 and 2'b01 otherwise. All other bits are 0. The bank-3 word is all zeros.
- R12: While cmd_valid is 1 and cmd_ready is 0, cmd_valid, cmd_bank and cmd_addr hold unchanged.
- R13: If a command waits more than CMD_TIMEOUT cycles without cmd_ready, error becomes 1 and cmd_valid drops, while done stays 0. dram_reset_n, cke and odt_force_low keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request to begin |
| resume | input | 1 | Resume from suspend: skip the sequence |
| rank_map | input | RANKS | Populated ranks |
| dual_dimm | input | 1 | Two DIMMs share the channel |
| cas_lat | input | 4 | CAS latency in clocks |
| cas_wr_lat | input | 4 | CAS write latency in clocks |
| wr_rec | input | 5 | Write recovery in clocks |
| rtt_wr_hi | input | 1 | Selects 120 ohm dynamic write termination, else 60 ohm |
| cmd_ready | input | 1 | Command port accepts the presented command |
| dram_reset_n | output | 1 | DRAM reset, active low |
| dram_clk_en | output | 1 | Enables the DRAM clock |
| cke | output | RANKS | Per-rank clock-enable override |
| odt_force_low | output | 1 | Forces termination low on all ranks |
| cmd_valid | output | 1 | Command presented |
| cmd_is_zq | output | 1 | 1: ZQ calibration, 0: mode-register write |
| cmd_bank | output | 3 | Bank address (mode-register number) |
| cmd_addr | output | 16 | Address-bus word |
| cmd_ranks | output | RANKS | Ranks targeted by the command |
| done | output | 1 | Sequence complete or bypassed |
| error | output | 1 | Illegal write recovery or command timeout |

## Verification
A start pulse is registered on the next rising edge, so a resume or an illegal tWR shows done or error one edge later. A command counts as accepted on the rising edge where cmd_valid and cmd_ready are both high, and the next word or done appears just after that edge. The bench drives inputs 5 ns after each rising edge and samples outputs on the falling edge, so each sample sees values that have already settled. Each minimum wait is measured as a count of falling-edge samples in that phase and compared against its parameter with a greater-or-equal test, because the block may hold a phase one cycle longer than the minimum.

// File: rtl/ddr3_init_pkg.sv
package ddr3_init_pkg;

  typedef enum logic [3:0] {
    SQ_IDLE,
    SQ_PREP,
    SQ_RST,
    SQ_STAB,
    SQ_CLKWAIT,
    SQ_XPR,
    SQ_CMD,
    SQ_DONE,
    SQ_FAIL
  } seq_state_e;

  // command steps, issued in this order
  localparam logic [2:0] STEP_MR2 = 3'd0;
  localparam logic [2:0] STEP_MR3 = 3'd1;
  localparam logic [2:0] STEP_MR1 = 3'd2;
  localparam logic [2:0] STEP_MR0 = 3'd3;
  localparam logic [2:0] STEP_ZQ  = 3'd4;

  function automatic int unsigned umax(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  function automatic logic wr_legal(input logic [4:0] t);
    return (t >= 5'd5) && (t <= 5'd16);
  endfunction

  // write-recovery field code for a legal tWR
  function automatic logic [2:0] wr_code(input logic [4:0] t);
    logic [2:0] c;
    if (t <= 5'd8)       c = 3'(t - 5'd4);
    else if (t <= 5'd14) c = 3'(((t - 5'd9) >> 1) + 5'd5);
    else                 c = 3'd0;
    return c;
  endfunction

endpackage

// File: rtl/ddr3_init_timer.sv
module ddr3_init_timer #(
  parameter int unsigned CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          zero
);

  logic [CW-1:0] cnt_q;
  logic          cnt_en;

  assign zero   = (cnt_q == '0);
  assign cnt_en = load | ~zero;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= load ? load_val : (cnt_q - 1'b1);
    end
  end

endmodule

// File: rtl/ddr3_mr_builder.sv
module ddr3_mr_builder
  import ddr3_init_pkg::*;
(
  input  logic [2:0]  step,
  input  logic [3:0]  cas_lat,
  input  logic [3:0]  cas_wr_lat,
  input  logic [4:0]  wr_rec,
  input  logic        dual_dimm,
  input  logic        rtt_wr_hi,
  output logic [15:0] addr,
  output logic [2:0]  bank,
  output logic        is_zq
);

  logic [3:0] cl_code;
  assign cl_code = cas_lat - 4'd4;

  always_comb begin
    addr  = '0;
    bank  = 3'd0;
    is_zq = 1'b0;
    unique case (step)
      STEP_MR2: begin
        bank       = 3'd2;
        addr[5:3]  = 3'(cas_wr_lat - 4'd5);
        addr[10:9] = rtt_wr_hi ? 2'b10 : 2'b01;
      end
      STEP_MR3: begin
        bank = 3'd3;
      end
      STEP_MR1: begin
        bank    = 3'd1;
        addr[1] = 1'b1;
        addr[2] = dual_dimm;
      end
      STEP_MR0: begin
        bank       = 3'd0;
        addr[2]    = cl_code[3];
        addr[6:4]  = cl_code[2:0];
        addr[8]    = 1'b1;
        addr[11:9] = wr_code(wr_rec);
      end
      default: begin
        is_zq    = 1'b1;
        addr[10] = 1'b1;
      end
    endcase
  end

endmodule

// File: rtl/ddr3_rst_sync.sv
module ddr3_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr_q <= '0;
    else        sr_q <= {sr_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sr_q[STAGES-1];

endmodule

// File: rtl/ddr3_powerup_seq.sv
module ddr3_powerup_seq
  import ddr3_init_pkg::*;
#(
  parameter int unsigned RANKS       = 4,
  parameter int unsigned T_RESET_CYC = 10000,
  parameter int unsigned T_STAB_CYC  = 25000,
  parameter int unsigned T_CKSRX_CYC = 2,
  parameter int unsigned T_XPR_CYC   = 16,
  parameter int unsigned CMD_TIMEOUT = 1024
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             resume,
  input  logic [RANKS-1:0] rank_map,
  input  logic             dual_dimm,
  input  logic [3:0]       cas_lat,
  input  logic [3:0]       cas_wr_lat,
  input  logic [4:0]       wr_rec,
  input  logic             rtt_wr_hi,
  input  logic             cmd_ready,
  output logic             dram_reset_n,
  output logic             dram_clk_en,
  output logic [RANKS-1:0] cke,
  output logic             odt_force_low,
  output logic             cmd_valid,
  output logic             cmd_is_zq,
  output logic [2:0]       cmd_bank,
  output logic [15:0]      cmd_addr,
  output logic [RANKS-1:0] cmd_ranks,
  output logic             done,
  output logic             error
);

  localparam int unsigned T_MAX = umax(umax(umax(T_RESET_CYC, T_STAB_CYC),
                                            umax(T_CKSRX_CYC, T_XPR_CYC)), CMD_TIMEOUT);
  localparam int unsigned CW    = $clog2(T_MAX + 1);

  logic             rst_sync_n;
  seq_state_e       state_q, state_d;
  logic [2:0]       step_q, step_d;
  logic             rstn_q, rstn_d;
  logic             clken_q, clken_d;
  logic             odt_q, odt_d;
  logic [RANKS-1:0] cke_q, cke_d;
  logic             seq_upd;
  logic             t_load, t_zero;
  logic [CW-1:0]    t_val;

  ddr3_rst_sync #(.STAGES(2)) i_rst_sync (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  ddr3_init_timer #(.CW(CW)) i_timer (
    .clk(clk), .rst_n(rst_sync_n), .load(t_load), .load_val(t_val), .zero(t_zero)
  );

  ddr3_mr_builder i_mr_builder (
    .step(step_q), .cas_lat(cas_lat), .cas_wr_lat(cas_wr_lat), .wr_rec(wr_rec),
    .dual_dimm(dual_dimm), .rtt_wr_hi(rtt_wr_hi),
    .addr(cmd_addr), .bank(cmd_bank), .is_zq(cmd_is_zq)
  );

  // next-state logic
  always_comb begin
    state_d = state_q;
    step_d  = step_q;
    rstn_d  = rstn_q;
    clken_d = clken_q;
    odt_d   = odt_q;
    cke_d   = cke_q;
    t_load  = 1'b0;
    t_val   = '0;
    unique case (state_q)
      SQ_IDLE: begin
        if (start) begin
          if (resume)                state_d = SQ_DONE;
          else if (!wr_legal(wr_rec)) state_d = SQ_FAIL;
          else begin
            state_d = SQ_PREP;
            odt_d   = 1'b1;
          end
        end
      end
      SQ_PREP: begin
        state_d = SQ_RST;
        rstn_d  = 1'b0;
        cke_d   = '0;
        t_load  = 1'b1;
        t_val   = CW'(T_RESET_CYC);
      end
      SQ_RST: begin
        if (t_zero) begin
          state_d = SQ_STAB;
          rstn_d  = 1'b1;
          t_load  = 1'b1;
          t_val   = CW'(T_STAB_CYC);
        end
      end
      SQ_STAB: begin
        if (t_zero) begin
          state_d = SQ_CLKWAIT;
          clken_d = 1'b1;
          t_load  = 1'b1;
          t_val   = CW'(T_CKSRX_CYC);
        end
      end
      SQ_CLKWAIT: begin
        if (t_zero) begin
          state_d = SQ_XPR;
          cke_d   = rank_map;
          t_load  = 1'b1;
          t_val   = CW'(T_XPR_CYC);
        end
      end
      SQ_XPR: begin
        if (t_zero) begin
          state_d = SQ_CMD;
          step_d  = STEP_MR2;
          t_load  = 1'b1;
          t_val   = CW'(CMD_TIMEOUT);
        end
      end
      SQ_CMD: begin
        if (cmd_ready) begin
          if (step_q == STEP_ZQ) begin
            state_d = SQ_DONE;
            odt_d   = 1'b0;
          end else begin
            step_d = step_q + 3'd1;
            t_load = 1'b1;
            t_val  = CW'(CMD_TIMEOUT);
          end
        end else if (t_zero) begin
          state_d = SQ_FAIL;
        end
      end
      default: ;
    endcase
  end

  assign seq_upd = (state_d != state_q) || (step_d != step_q);

  // state registers
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      state_q <= SQ_IDLE;
      step_q  <= STEP_MR2;
      rstn_q  <= 1'b1;
      clken_q <= 1'b0;
      odt_q   <= 1'b0;
      cke_q   <= '0;
    end else if (seq_upd) begin
      state_q <= state_d;
      step_q  <= step_d;
      rstn_q  <= rstn_d;
      clken_q <= clken_d;
      odt_q   <= odt_d;
      cke_q   <= cke_d;
    end
  end

  assign dram_reset_n  = rstn_q;
  assign dram_clk_en   = clken_q;
  assign cke           = cke_q;
  assign odt_force_low = odt_q;
  assign cmd_valid     = (state_q == SQ_CMD);
  assign cmd_ranks     = cke_q;
  assign done          = (state_q == SQ_DONE);
  assign error         = (state_q == SQ_FAIL);

endmodule

// File: rtl/ddr3_powerup_seq_chk.sv
module ddr3_powerup_seq_chk #(
  parameter int unsigned RANKS       = 4,
  parameter int unsigned T_RESET_CYC = 1,
  parameter int unsigned T_STAB_CYC  = 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             dram_reset_n,
  input logic             dram_clk_en,
  input logic [RANKS-1:0] cke,
  input logic             odt_force_low,
  input logic             cmd_valid,
  input logic             cmd_ready,
  input logic [15:0]      cmd_addr,
  input logic [2:0]       cmd_bank,
  input logic             done,
  input logic             error
);

  logic [31:0] low_cnt, stab_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             low_cnt <= '0;
    else if (!dram_reset_n) low_cnt <= low_cnt + 32'd1;
    else                    low_cnt <= '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                            stab_cnt <= '0;
    else if (dram_reset_n && !dram_clk_en) stab_cnt <= stab_cnt + 32'd1;
    else                                   stab_cnt <= '0;
  end

  AST_CKE_LOW_IN_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    !dram_reset_n |-> (cke == '0)); // R4
  AST_ODT_IN_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    !dram_reset_n |-> odt_force_low); // R3
  AST_ODT_OFF_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !odt_force_low); // R3
  AST_RESET_MIN_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dram_reset_n) |-> (low_cnt >= 32'(T_RESET_CYC))); // R5
  AST_CLK_AFTER_STAB: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dram_clk_en) |-> (stab_cnt >= 32'(T_STAB_CYC))); // R5
  AST_CMD_NEEDS_CLK: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> (dram_clk_en && dram_reset_n && odt_force_low)); // R6
  AST_CMD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_ready) |=> (error || (cmd_valid && $stable(cmd_addr) && $stable(cmd_bank)))); // R12
  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> done); // R2
  AST_DONE_ERR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && error)); // R13

endmodule

bind ddr3_powerup_seq ddr3_powerup_seq_chk #(
  .RANKS(RANKS), .T_RESET_CYC(T_RESET_CYC), .T_STAB_CYC(T_STAB_CYC)
) i_chk (
  .clk(clk), .rst_n(rst_sync_n), .dram_reset_n(dram_reset_n), .dram_clk_en(dram_clk_en),
  .cke(cke), .odt_force_low(odt_force_low), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .cmd_addr(cmd_addr), .cmd_bank(cmd_bank), .done(done), .error(error)
);

// File: tb/test_ddr3_powerup_seq.sv
`timescale 1ns/1ps
module test_ddr3_powerup_seq;

  localparam int TR = 20, TS = 30, TC = 3, TX = 6, TO = 15;

  logic clk, rst_n, start, resume, dual_dimm, rtt_wr_hi, cmd_ready;
  logic [3:0] rank_map, cas_lat, cas_wr_lat, cke, cmd_ranks;
  logic [4:0] wr_rec;
  logic dram_reset_n, dram_clk_en, odt_force_low, cmd_valid, cmd_is_zq, done, error;
  logic [2:0] cmd_bank;
  logic [15:0] cmd_addr;

  ddr3_powerup_seq #(.RANKS(4), .T_RESET_CYC(TR), .T_STAB_CYC(TS), .T_CKSRX_CYC(TC),
                     .T_XPR_CYC(TX), .CMD_TIMEOUT(TO)) i_ddr3_powerup_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .resume(resume), .rank_map(rank_map),
    .dual_dimm(dual_dimm), .cas_lat(cas_lat), .cas_wr_lat(cas_wr_lat), .wr_rec(wr_rec),
    .rtt_wr_hi(rtt_wr_hi), .cmd_ready(cmd_ready), .dram_reset_n(dram_reset_n),
    .dram_clk_en(dram_clk_en), .cke(cke), .odt_force_low(odt_force_low),
    .cmd_valid(cmd_valid), .cmd_is_zq(cmd_is_zq), .cmd_bank(cmd_bank), .cmd_addr(cmd_addr),
    .cmd_ranks(cmd_ranks), .done(done), .error(error)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  int checks = 0, errors = 0;

  task automatic chk_eq(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  task automatic chk_ge(input string req, input string what, input int act, input int lim);
    checks++;
    if (act < lim) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected>=%0d", req, what, act, lim);
    end
  endtask

  // command responder
  bit rdy_en = 0;
  int rdy_delay = 0, wcnt = 0;
  initial cmd_ready = 1'b0;
  always @(posedge clk) begin
    #5;
    if (!rdy_en) cmd_ready = 1'b0;
    else if (rdy_delay == 0) cmd_ready = 1'b1;
    else if (cmd_ready) begin cmd_ready = 1'b0; wcnt = 0; end
    else if (cmd_valid) begin
      wcnt++;
      if (wcnt >= rdy_delay) cmd_ready = 1'b1;
    end
  end

  // monitor, sampled on the falling edge
  int rst_low, stab, cksrx, xpr, ncmd, valid_cyc;
  bit seen_reset, cke_bad, odt_pre, odt_gap, hold_bad, odt_last, prev_v, prev_r;
  logic [3:0] cke_last;
  logic [23:0] prev_w;
  logic [23:0] log_w [8];
  wire  [23:0] cur_w = {cmd_is_zq, cmd_bank, cmd_addr, cmd_ranks};

  task automatic clear_mon();
    rst_low = 0; stab = 0; cksrx = 0; xpr = 0; ncmd = 0; valid_cyc = 0;
    seen_reset = 0; cke_bad = 0; odt_pre = 0; odt_gap = 0; hold_bad = 0; odt_last = 0;
    prev_v = 0; prev_r = 0; cke_last = '0; prev_w = '0;
  endtask

  always @(negedge clk) begin
    if (!dram_reset_n) begin
      rst_low++; seen_reset = 1;
      if (cke != 0) cke_bad = 1;
    end
    if (dram_reset_n && odt_force_low && !seen_reset) odt_pre = 1;
    if (dram_reset_n && seen_reset && !dram_clk_en) stab++;
    if (dram_clk_en && cke == 0) cksrx++;
    if (cke != 0 && ncmd == 0 && !cmd_valid) xpr++;
    if (cke != 0) cke_last = cke;
    if (seen_reset && !done && !error && !odt_force_low) odt_gap = 1;
    if (prev_v && !prev_r && !error && (!cmd_valid || cur_w != prev_w)) hold_bad = 1;
    if (cmd_valid && cmd_ready) begin
      if (ncmd < 8) log_w[ncmd] = cur_w;
      if (cmd_is_zq) odt_last = odt_force_low;
      ncmd++;
    end
    if (cmd_valid) valid_cyc++;
    prev_v = cmd_valid; prev_r = cmd_ready; prev_w = cur_w;
  end

  task automatic settle();
    @(negedge clk); #1;
  endtask

  task automatic reset_dut();
    rdy_en = 0; start = 0; resume = 0;
    rank_map = 4'b0001; dual_dimm = 0; cas_lat = 4'd6; cas_wr_lat = 4'd5;
    wr_rec = 5'd8; rtt_wr_hi = 0;
    rst_n = 0;
    repeat (3) @(posedge clk);
    #5 rst_n = 1;
    repeat (4) @(posedge clk);
    #5 clear_mon();
    settle();
    chk_eq("R1", "idle dram_reset_n", dram_reset_n, 1);
    chk_eq("R1", "idle cke", cke, 0);
    chk_eq("R1", "idle dram_clk_en", dram_clk_en, 0);
    chk_eq("R1", "idle odt_force_low", odt_force_low, 0);
    chk_eq("R1", "idle cmd_valid/done/error", {cmd_valid, done, error}, 0);
  endtask

  task automatic pulse_start();
    @(posedge clk); #5 start = 1;
    @(posedge clk); #5 start = 0;
  endtask

  function automatic logic [2:0] exp_wr(input int t);
    logic [2:0] tab [12] = '{3'd1, 3'd2, 3'd3, 3'd4, 3'd5, 3'd5, 3'd6, 3'd6, 3'd7, 3'd7, 3'd0, 3'd0};
    return tab[t-5];
  endfunction

  task automatic run_full(input logic [3:0] rk, input bit dual, input int cl, input int cwl,
                          input int twr, input bit rhi, input int dly);
    logic [15:0] mr0, mr1, mr2;
    int cc;
    reset_dut();
    rank_map = rk; dual_dimm = dual; cas_lat = 4'(cl); cas_wr_lat = 4'(cwl);
    wr_rec = 5'(twr); rtt_wr_hi = rhi; rdy_delay = dly; rdy_en = 1;
    pulse_start();
    for (int i = 0; i < 3000 && !done && !error; i++) @(negedge clk);
    settle();
    cc  = cl - 4;
    mr0 = 16'((int'(exp_wr(twr)) << 9) | (1 << 8) | ((cc & 7) << 4) | (((cc >> 3) & 1) << 2));
    mr1 = 16'(2 | (dual ? 4 : 0));
    mr2 = 16'((((cwl - 5) & 7) << 3) | ((rhi ? 2 : 1) << 9));
    chk_eq("R7", "done after sequence", done, 1);
    chk_eq("R7", "error after sequence", error, 0);
    chk_ge("R5", "reset low cycles", rst_low, TR);
    chk_ge("R5", "clock-off cycles after reset", stab, TS);
    chk_ge("R6", "cke-low cycles after clock", cksrx, TC);
    chk_ge("R6", "cycles before first command", xpr, TX);
    chk_eq("R6", "cke equals rank map", cke_last, rk);
    chk_eq("R4", "cke raised during reset", cke_bad, 0);
    chk_eq("R3", "odt forced before reset", odt_pre, 1);
    chk_eq("R3", "odt released mid-sequence", odt_gap, 0);
    chk_eq("R3", "odt at ZQ accept", odt_last, 1);
    chk_eq("R3", "odt released at done", odt_force_low, 0);
    chk_eq("R12", "word held while waiting", hold_bad, 0);
    chk_eq("R7", "command count", ncmd, 5);
    chk_eq("R11", "MR2 word", log_w[0], {1'b0, 3'd2, mr2, rk});
    chk_eq("R11", "MR3 word", log_w[1], {1'b0, 3'd3, 16'h0000, rk});
    chk_eq("R10", "MR1 word", log_w[2], {1'b0, 3'd1, mr1, rk});
    chk_eq("R8", "MR0 word", log_w[3], {1'b0, 3'd0, mr0, rk});
    chk_eq("R9", "write recovery field", log_w[3][15:13], exp_wr(twr));
    chk_eq("R7", "ZQ word", log_w[4], {1'b1, 3'd0, 16'h0400, rk});
  endtask

  task automatic run_resume();
    reset_dut();
    rank_map = 4'b1111; resume = 1; rdy_en = 1; rdy_delay = 0;
    pulse_start();
    settle();
    chk_eq("R2", "done one edge after start", done, 1);
    repeat (20) @(negedge clk);
    settle();
    chk_eq("R2", "done held", done, 1);
    chk_eq("R2", "reset never pulsed", seen_reset, 0);
    chk_eq("R2", "no commands", ncmd, 0);
    chk_eq("R2", "clock and cke untouched", {dram_clk_en, cke}, 0);
    chk_eq("R2", "error low", error, 0);
    resume = 0;
  endtask

  task automatic run_bad_twr(input int twr);
    reset_dut();
    wr_rec = 5'(twr); rdy_en = 1; rdy_delay = 0;
    pulse_start();
    settle();
    chk_eq("R9", "illegal tWR error", error, 1);
    repeat (15) @(negedge clk);
    settle();
    chk_eq("R9", "no reset on illegal tWR", seen_reset, 0);
    chk_eq("R9", "no command on illegal tWR", ncmd, 0);
    chk_eq("R9", "done low on illegal tWR", done, 0);
  endtask

  task automatic run_timeout();
    reset_dut();
    rank_map = 4'b0110; wr_rec = 5'd10; rdy_en = 0;
    pulse_start();
    for (int i = 0; i < 500 && !error; i++) @(negedge clk);
    settle();
    chk_eq("R13", "error on timeout", error, 1);
    chk_eq("R13", "done low", done, 0);
    chk_eq("R13", "cmd_valid dropped", cmd_valid, 0);
    chk_ge("R13", "valid cycles before timeout", valid_cyc, TO);
    chk_eq("R13", "no command accepted", ncmd, 0);
    repeat (10) @(negedge clk);
    settle();
    chk_eq("R13", "reset held released", dram_reset_n, 1);
    chk_eq("R13", "cke held", cke, 4'b0110);
    chk_eq("R13", "odt held", odt_force_low, 1);
    chk_eq("R13", "error sticky", error, 1);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL R7 watchdog: actual=expired expected=finished");
    summary();
    $finish;
  end

  initial begin
    clear_mon();
    run_full(4'b0011, 0, 11, 8, 12, 0, 0);
    run_full(4'b1111, 1, 13, 9, 16, 1, 3);
    run_full(4'b0101, 0, 6, 5, 5, 0, 1);
    run_full(4'b1000, 1, 9, 7, 9, 1, 2);
    run_resume();
    run_bad_twr(4);
    run_bad_twr(17);
    run_timeout();
    summary();
    $finish;
  end

endmodule